// File: doc/BRIEF.md
# Keyed Boot-Entry Jump Gate

This block guards the instruction that hands control from the flash program store to the boot ROM. Software opens a short unlock window by storing one byte to a memory-mapped key register. If the upper six bits of that byte carry the unlock pattern, an unlock flag rises and stays up for a fixed number of completed instruction cycles. A jump-to-boot instruction executed while the flag is up lands at the boot ROM entry point. A jump executed at any other time quietly goes to the flash address encoded in the instruction. Stray code that runs away into the jump opcode therefore cannot reach the boot ROM without first storing the key.

The countdown moves only on the core's instruction-complete strobe. It is frozen while a debug halt is asserted, so stepping through code in a debugger does not use up the window. Each unlock is good for one jump, because a jump-to-boot closes the window at once. The current flag can be read back at bit 0 of the key register.

Top module: `bootjump_guard`

## Requirements
- R1: A store with `bus_we`=1 and `bus_addr` equal to the key address (default 8'hC7) is a matching key when `bus_wdata[7:2]` equals 6'b100110. Bits 1 and 0 are ignored, so 8'h98, 8'h99, 8'h9A and 8'h9B all match.
- R2: After a matching store the unlock flag is set from the next cycle on. It stays set through exactly 8 instruction-complete strobes and reads clear after the 8th.
- R3: A store whose upper six bits differ from the pattern, or a store to any other address, leaves the flag and its remaining count unchanged.
- R4: When `jmp_boot` is high and the flag is set, `fetch_valid`=1, `fetch_boot`=1 and `fetch_pc` equals the boot entry address (default 0), in the same cycle.
- R5: When `jmp_boot` is high and the flag is clear, `fetch_valid`=1, `fetch_boot`=0 and `fetch_pc` equals `jmp_target`. When `jmp_boot` is low, `fetch_valid`=0.
- R6: While `dbg_halt` is high, instruction-complete strobes do not advance the countdown. Counting resumes when the halt drops.
- R7: Cycles without `icyc_done` do not advance the countdown.
- R8: A matching store while the flag is already set reloads the countdown to a full 8 strobes.
- R9: A jump-to-boot clears the flag from the next cycle, so one unlock allows one boot entry. A matching store in the same cycle as the jump takes precedence and leaves a fresh full window.
- R10: Reset (synchronous, active high) clears the flag. `bus_rdata` is {7'b0, flag} when `bus_addr` is the key address, and 8'h00 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Data-bus address |
| bus_we | input | 1 | Data-bus store strobe |
| bus_wdata | input | 8 | Data-bus store data |
| bus_rdata | output | 8 | Read data; flag at bit 0 when the key address is selected |
| icyc_done | input | 1 | One pulse per completed instruction cycle |
| dbg_halt | input | 1 | Debug breakpoint halt; freezes the countdown |
| jmp_boot | input | 1 | Jump-to-boot instruction executing this cycle |
| jmp_target | input | 15 | Flash target carried by the jump instruction |
| fetch_valid | output | 1 | Resolved fetch address is valid |
| fetch_pc | output | 15 | Resolved next fetch address |
| fetch_boot | output | 1 | 1 selects boot ROM, 0 selects flash |

## Verification
The bench walks the window edges. It checks the flag after the 7th and after the 8th strobe. A counter that is off by one leaves the window open a strobe too long or closes it a strobe early. Stores that differ only in bits 1:0, stores with a wrong pattern and stores to a neighbouring address are used to catch a compare that is too wide or one that is not address-qualified. Halted strobes, idle cycles, a reload in mid-window, a second jump after a boot entry, and a jump that coincides with a key store are each aimed at a design that keeps counting under halt, lets one unlock pay for two jumps, or gives the wrong update priority. Long seeded random traffic then compares every output against a reference model.

// File: rtl/bootjump_pkg.sv
package bootjump_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned KEY_W  = 6;

    typedef enum logic {
        SPACE_FLASH = 1'b0,
        SPACE_BOOT  = 1'b1
    } space_e;

    // Control bundle for the unlock countdown, in priority order reload > consume > tick.
    typedef struct packed {
        logic reload;
        logic consume;
        logic tick;
        logic hold;
    } timer_ctl_t;

    function automatic logic key_hit(input logic [DATA_W-1:0] data,
                                     input logic [KEY_W-1:0]  pattern);
        return data[DATA_W-1 -: KEY_W] == pattern;
    endfunction

endpackage

// File: rtl/key_decode.sv
module key_decode
    import bootjump_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] KEY_ADDR = 8'hC7,
    parameter logic [KEY_W-1:0]  KEY_PATTERN = 6'b100110
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              key_flag,
    output logic              unlock,
    output logic [DATA_W-1:0] rdata
);
    logic selected;

    always_comb begin
        selected = (bus_addr == KEY_ADDR);
        unlock   = selected && bus_we && key_hit(bus_wdata, KEY_PATTERN);
        rdata    = '0;
        if (selected) begin
            rdata[0] = key_flag;
        end
    end

endmodule

// File: rtl/key_timer.sv
module key_timer
    import bootjump_pkg::*;
#(
    parameter int unsigned WINDOW = 8,
    localparam int unsigned CNT_W = $clog2(WINDOW + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  timer_ctl_t ctl,
    output logic       key_flag
);
    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (ctl.reload) begin
            remain <= CNT_W'(WINDOW);
        end else if (ctl.consume) begin
            remain <= '0;
        end else if (ctl.tick && !ctl.hold && remain != '0) begin
            remain <= remain - CNT_W'(1);
        end
    end

    assign key_flag = (remain != '0);

    assert_reload_full_R8: assert property (@(posedge clk) disable iff (rst)
        ctl.reload |=> (remain == CNT_W'(WINDOW)));

    assert_consume_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (ctl.consume && !ctl.reload) |=> !key_flag);

    assert_halt_freezes_R6: assert property (@(posedge clk) disable iff (rst)
        (ctl.hold && !ctl.reload && !ctl.consume) |=> $stable(remain));

    assert_idle_stable_R7: assert property (@(posedge clk) disable iff (rst)
        (!ctl.tick && !ctl.reload && !ctl.consume) |=> $stable(remain));

    assert_single_step_R2: assert property (@(posedge clk) disable iff (rst)
        (ctl.tick && !ctl.hold && !ctl.reload && !ctl.consume && key_flag)
        |=> (remain == $past(remain) - CNT_W'(1)));

    assert_window_bound_R2: assert property (@(posedge clk) disable iff (rst)
        remain <= CNT_W'(WINDOW));

endmodule

// File: rtl/jump_resolve.sv
module jump_resolve
    import bootjump_pkg::*;
#(
    parameter int unsigned PC_W = 15,
    parameter logic [PC_W-1:0] BOOT_ENTRY = '0
) (
    input  logic            jmp,
    input  logic [PC_W-1:0] flash_target,
    input  logic            key_flag,
    output logic            valid,
    output logic [PC_W-1:0] next_pc,
    output space_e          space
);
    always_comb begin
        valid   = jmp;
        space   = SPACE_FLASH;
        next_pc = flash_target;
        if (jmp && key_flag) begin
            space   = SPACE_BOOT;
            next_pc = BOOT_ENTRY;
        end
    end

endmodule

// File: rtl/bootjump_guard.sv
module bootjump_guard
    import bootjump_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned PC_W   = 15,
    parameter int unsigned WINDOW = 8,
    parameter logic [ADDR_W-1:0] KEY_ADDR    = 8'hC7,
    parameter logic [KEY_W-1:0]  KEY_PATTERN = 6'b100110,
    parameter logic [PC_W-1:0]   BOOT_ENTRY  = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              icyc_done,
    input  logic              dbg_halt,
    input  logic              jmp_boot,
    input  logic [PC_W-1:0]   jmp_target,
    output logic              fetch_valid,
    output logic [PC_W-1:0]   fetch_pc,
    output logic              fetch_boot
);
    logic       unlock;
    logic       key_flag;
    timer_ctl_t ctl;
    space_e     space;

    key_decode #(
        .ADDR_W      (ADDR_W),
        .KEY_ADDR    (KEY_ADDR),
        .KEY_PATTERN (KEY_PATTERN)
    ) u_decode (
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .key_flag  (key_flag),
        .unlock    (unlock),
        .rdata     (bus_rdata)
    );

    always_comb begin
        ctl.reload  = unlock;
        ctl.consume = jmp_boot;
        ctl.tick    = icyc_done;
        ctl.hold    = dbg_halt;
    end

    key_timer #(
        .WINDOW (WINDOW)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .key_flag (key_flag)
    );

    jump_resolve #(
        .PC_W       (PC_W),
        .BOOT_ENTRY (BOOT_ENTRY)
    ) u_resolve (
        .jmp          (jmp_boot),
        .flash_target (jmp_target),
        .key_flag     (key_flag),
        .valid        (fetch_valid),
        .next_pc      (fetch_pc),
        .space        (space)
    );

    assign fetch_boot = (space == SPACE_BOOT);

    assert_boot_route_R4: assert property (@(posedge clk) disable iff (rst)
        (jmp_boot && key_flag) |-> (fetch_boot && fetch_pc == BOOT_ENTRY));

    assert_flash_route_R5: assert property (@(posedge clk) disable iff (rst)
        (jmp_boot && !key_flag) |-> (!fetch_boot && fetch_pc == jmp_target));

    assert_read_mirror_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == KEY_ADDR) |-> (bus_rdata == {7'b0, key_flag}));

    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> !key_flag);

endmodule

// File: tb/bootjump_guard_bench.sv
`timescale 1ns/1ps
module bootjump_guard_bench;
    localparam logic [7:0]  KADDR = 8'hC7;
    localparam logic [14:0] BOOT  = 15'd0;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  bus_addr;
    logic        bus_we;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic        icyc_done;
    logic        dbg_halt;
    logic        jmp_boot;
    logic [14:0] jmp_target;
    logic        fetch_valid;
    logic [14:0] fetch_pc;
    logic        fetch_boot;

    int checks = 0;
    int errors = 0;
    int m_cnt  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    bootjump_guard u_bootjump_guard (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .icyc_done(icyc_done),
        .dbg_halt(dbg_halt), .jmp_boot(jmp_boot), .jmp_target(jmp_target),
        .fetch_valid(fetch_valid), .fetch_pc(fetch_pc), .fetch_boot(fetch_boot)
    );

    function automatic bit is_match(input logic [7:0] a, input logic we, input logic [7:0] d);
        return we && a == KADDR && d[7:2] == 6'b100110;
    endfunction

    function automatic int next_cnt(input int c, input bit match, input bit jmp,
                                    input bit tick, input bit halt);
        if (match) return 8;
        if (jmp) return 0;
        if (tick && !halt && c > 0) return c - 1;
        return c;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one cycle, check outputs against the model, then advance the model.
    task automatic step(input logic [7:0] a, input logic we, input logic [7:0] d,
                        input logic tick, input logic halt, input logic jmp,
                        input logic [14:0] tgt);
        bit key;
        @(negedge clk);
        bus_addr = a; bus_we = we; bus_wdata = d; icyc_done = tick;
        dbg_halt = halt; jmp_boot = jmp; jmp_target = tgt;
        #1;
        key = (m_cnt != 0);
        chk("R10 rdata", 32'(bus_rdata), (a == KADDR) ? 32'(key) : 32'd0);
        chk("R5 fetch_valid", 32'(fetch_valid), 32'(jmp));
        if (jmp) begin
            if (key) begin
                chk("R4 fetch_boot", 32'(fetch_boot), 32'd1);
                chk("R4 fetch_pc", 32'(fetch_pc), 32'(BOOT));
            end else begin
                chk("R5 fetch_boot", 32'(fetch_boot), 32'd0);
                chk("R5 fetch_pc", 32'(fetch_pc), 32'(tgt));
            end
        end
        @(posedge clk);
        m_cnt = next_cnt(m_cnt, is_match(a, we, d), jmp, tick, halt);
    endtask

    task automatic idle(input logic tick, input logic halt);
        step(8'h00, 1'b0, 8'h00, tick, halt, 1'b0, 15'h0);
    endtask

    // Read the flag through the bus with a literal expectation.
    task automatic peek(input string req, input logic exp);
        @(negedge clk);
        bus_addr = KADDR; bus_we = 1'b0; icyc_done = 1'b0; dbg_halt = 1'b0; jmp_boot = 1'b0;
        #1;
        chk(req, 32'(bus_rdata), {31'd0, exp});
        @(posedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = int'($urandom(32'd4242));
        rst = 1'b1; bus_addr = 0; bus_we = 0; bus_wdata = 0; icyc_done = 0;
        dbg_halt = 0; jmp_boot = 0; jmp_target = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        m_cnt = 0;

        // Reset state
        peek("R10 reset flag", 1'b0);
        step(8'h00, 0, 8'h00, 0, 0, 1, 15'h1234);        // R5 jump while locked

        // R2 exact window, R1 pattern 8'h98
        step(KADDR, 1, 8'h98, 0, 0, 0, 0);
        peek("R1 set by 98", 1'b1);
        for (int i = 0; i < 7; i++) idle(1, 0);
        peek("R2 set after 7 strobes", 1'b1);
        idle(1, 0);
        peek("R2 clear after 8 strobes", 1'b0);

        // R1 don't-care low bits, R7 idle, R6 halt
        step(KADDR, 1, 8'h9B, 0, 0, 0, 0);
        peek("R1 set by 9B", 1'b1);
        for (int i = 0; i < 12; i++) idle(0, 0);
        peek("R7 idle no advance", 1'b1);
        for (int i = 0; i < 12; i++) idle(1, 1);
        peek("R6 halted no advance", 1'b1);
        for (int i = 0; i < 7; i++) idle(1, 0);
        peek("R6 resumes 7", 1'b1);
        idle(1, 0);
        peek("R6 resumes 8", 1'b0);

        // R3 bad pattern and wrong address
        step(KADDR, 1, 8'h58, 0, 0, 0, 0);
        peek("R3 bad pattern", 1'b0);
        step(8'hC6, 1, 8'h98, 0, 0, 0, 0);
        peek("R3 wrong address", 1'b0);
        step(KADDR, 1, 8'h99, 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) idle(1, 0);
        step(KADDR, 1, 8'h18, 0, 0, 0, 0);
        for (int i = 0; i < 4; i++) idle(1, 0);
        peek("R3 count kept 7", 1'b1);
        idle(1, 0);
        peek("R3 count kept 8", 1'b0);

        // R8 reload
        step(KADDR, 1, 8'h9A, 0, 0, 0, 0);
        for (int i = 0; i < 5; i++) idle(1, 0);
        step(KADDR, 1, 8'h98, 0, 0, 0, 0);
        for (int i = 0; i < 7; i++) idle(1, 0);
        peek("R8 reloaded 7", 1'b1);
        idle(1, 0);
        peek("R8 reloaded 8", 1'b0);

        // R9 single use
        step(KADDR, 1, 8'h98, 0, 0, 0, 0);
        step(8'h00, 0, 8'h00, 1, 0, 1, 15'h2AAA);        // boot entry
        peek("R9 cleared by jump", 1'b0);
        step(8'h00, 0, 8'h00, 0, 0, 1, 15'h0555);        // flash
        chk("R9 second jump flash", 32'(fetch_boot), 32'd0);

        // R9 simultaneous store wins
        step(KADDR, 1, 8'h98, 0, 0, 0, 0);
        step(KADDR, 1, 8'h98, 0, 0, 1, 15'h0101);
        peek("R9 store beats jump", 1'b1);

        // Constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] a, d;
            logic we, tk, hl, jp;
            int r;
            r  = $urandom_range(0, 9);
            a  = (r < 6) ? KADDR : ((r < 8) ? 8'hC6 : 8'($urandom));
            we = ($urandom_range(0, 9) < 2);
            d  = ($urandom_range(0, 3) == 0) ? 8'($urandom) : {6'b100110, 2'($urandom)};
            tk = ($urandom_range(0, 2) != 0);
            hl = ($urandom_range(0, 5) == 0);
            jp = ($urandom_range(0, 7) == 0);
            step(a, we, d, tk, hl, jp, 15'($urandom));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule